// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits next to a small 8-bit CPU core and decides which interrupt the core takes next. It gathers requests from fixed nonmaskable sources (reset, the nonmaskable request pin, watchdog failure, illegal opcode, software interrupt) and from a maskable group (the maskable request pin plus twelve internal peripheral lines). It applies the CPU's I mask and a write-once enable for the nonmaskable pin, then picks a single winner. At an instruction boundary it raises a one-cycle take pulse and presents the winner's 16-bit vector address and source number.

Peripheral lines are edge-type. A one-cycle pulse on one of them is held pending until the CPU acknowledges that source by number. The two pins are level-type and are sampled directly. Software can move any one maskable source to the top of the maskable order through a small write port. The other maskable sources keep their default order.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst` is high, `take` is 0. In the first cycle after `rst` falls, `take` pulses with vector 0xFFFE and source 0. Reset also clears the promoted-source field to 0 and disables the nonmaskable pin.
- R2: Apart from the reset take, a request is accepted only when `boundary` was high in the cycle before `take` rises. Requests present while `boundary` is low produce no take.
- R3: While `cpu_i` is 1, maskable sources (numbers 5 to 17) are never taken. The nonmaskable sources are taken regardless of `cpu_i`.
- R4: `xirq_lvl` is ignored from reset until `cpu_x` has been seen at 0 in some cycle. From then on it stays enabled, even if `cpu_x` returns to 1, until the next reset.
- R5: The nonmaskable order is fixed: reset (0), nonmaskable pin (1, 0xFFF4), watchdog (2, 0xFFFA), illegal opcode (3, 0xFFF8), software interrupt (4, 0xFFF6). Any nonmaskable source beats every maskable one. The three strobes are held pending until their source is taken.
- R6: With no source promoted, the maskable order from highest to lowest is: maskable pin (index 0), real-time tick (1), captures 1 to 3 (2 to 4), compares 1 to 5 (5 to 9), timer overflow (10), pulse accumulator (11), serial (12). A maskable index k has source number k+5.
- R7: Writing k (0 to 12) through `pri_we`/`pri_wdata` promotes maskable index k above all other maskable sources. The rest keep their default order.
- R8: A write of a value 13 to 15 to the promoted-source field is ignored, and the previous promotion stays in effect.
- R9: Bit j of `periph_req` (maskable index j+1) is latched as pending. It is cleared only by an `ack` pulse whose `ack_id` equals j+6. An acknowledge for a different source leaves it pending.
- R10: `take` never stays high for two cycles in a row. `vec` and `src_id` change only in a cycle where `take` is high and hold until the next acceptance.
- R11: The vector for maskable index k is 0xFFF2 minus 2k for k from 0 to 11, and 0xFFD6 for k = 12.
- R12: `set_imask` is high in every cycle where `take` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset and reset request, active high |
| swi_stb | input | 1 | Software-interrupt strobe |
| ill_stb | input | 1 | Illegal-opcode strobe |
| wdog_stb | input | 1 | Watchdog-failure strobe |
| xirq_lvl | input | 1 | Nonmaskable pin request, level, active high |
| irq_lvl | input | 1 | Maskable pin request, level, active high |
| periph_req | input | 12 | Peripheral pulses; bit j is maskable index j+1 |
| cpu_i | input | 1 | CPU I mask bit |
| cpu_x | input | 1 | CPU X bit; a 0 enables the nonmaskable pin for good |
| boundary | input | 1 | Instruction-boundary strobe |
| pri_we | input | 1 | Write strobe for the promoted-source field |
| pri_wdata | input | 4 | Maskable index to promote |
| ack | input | 1 | Acknowledge pulse for a peripheral source |
| ack_id | input | 5 | Source number being acknowledged |
| take | output | 1 | One-cycle take-interrupt pulse |
| set_imask | output | 1 | Command to the CPU to set its I bit |
| vec | output | 16 | Vector address of the accepted source |
| src_id | output | 5 | Number of the accepted source |

## Verification
The bench first holds requests while `boundary` is low, and while `cpu_i` is 1. A controller that ignored the boundary or the mask would take at once, and the extra take would show up as unexpected. It drops `cpu_x` for a single cycle and later uses the nonmaskable pin with `cpu_x` back at 1. A non-sticky enable would lose that request. It acknowledges the wrong source number, then expects the same source to be taken again, which catches a pending latch that clears on any acknowledge. It writes an out-of-range promotion and expects the earlier promotion to survive. Finally it resets in mid-run and expects the default maskable order to return.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl (
  input  logic        clk,
  input  logic        rst,
  input  logic        swi_stb,
  input  logic        ill_stb,
  input  logic        wdog_stb,
  input  logic        xirq_lvl,
  input  logic        irq_lvl,
  input  logic [11:0] periph_req,
  input  logic        cpu_i,
  input  logic        cpu_x,
  input  logic        boundary,
  input  logic        pri_we,
  input  logic [3:0]  pri_wdata,
  input  logic        ack,
  input  logic [4:0]  ack_id,
  output logic        take,
  output logic        set_imask,
  output logic [15:0] vec,
  output logic [4:0]  src_id
);

  localparam logic [3:0] NMASK = 4'd13;

  logic        boot, xen;
  logic [2:0]  sw_pend, sw_now, sw_clr;
  logic [11:0] pend;
  logic [3:0]  prio;
  logic [12:0] elig;
  logic        hit, accept;
  logic [4:0]  wid;
  logic [15:0] wvec;

  function automatic logic [15:0] mvec(input logic [3:0] k);
    return (k == 4'd12) ? 16'hFFD6 : 16'hFFF2 - {11'd0, k, 1'b0};
  endfunction

  assign sw_now    = sw_pend | {swi_stb, ill_stb, wdog_stb};
  assign elig      = cpu_i ? 13'd0 : {pend | periph_req, irq_lvl};
  assign accept    = !take && (boot || (boundary && hit));
  assign sw_clr    = accept ? {wid == 5'd4, wid == 5'd3, wid == 5'd2} : 3'b000;
  assign set_imask = take;

  always_comb begin
    hit  = 1'b1;
    wid  = 5'd0;
    wvec = 16'hFFFE;
    if (boot) begin
    end else if (xirq_lvl && xen) begin
      wid = 5'd1; wvec = 16'hFFF4;
    end else if (sw_now[0]) begin
      wid = 5'd2; wvec = 16'hFFFA;
    end else if (sw_now[1]) begin
      wid = 5'd3; wvec = 16'hFFF8;
    end else if (sw_now[2]) begin
      wid = 5'd4; wvec = 16'hFFF6;
    end else if (prio < NMASK && elig[prio]) begin
      wid = 5'd5 + {1'b0, prio}; wvec = mvec(prio);
    end else begin
      hit = 1'b0;
      for (int k = 12; k >= 0; k--) begin
        if (elig[k]) begin
          hit  = 1'b1;
          wid  = 5'(k + 5);
          wvec = mvec(4'(k));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boot    <= 1'b1;
      xen     <= 1'b0;
      sw_pend <= 3'b000;
      pend    <= '0;
      prio    <= 4'd0;
      take    <= 1'b0;
      vec     <= 16'hFFFE;
      src_id  <= 5'd0;
    end else begin
      boot    <= 1'b0;
      take    <= accept;
      sw_pend <= sw_now & ~sw_clr;
      if (accept) begin
        vec    <= wvec;
        src_id <= wid;
      end
      if (!cpu_x) xen <= 1'b1;
      if (pri_we && pri_wdata < NMASK) prio <= pri_wdata;
      for (int j = 0; j < 12; j++)
        pend[j] <= (pend[j] & ~(ack && ack_id == 5'(j + 6))) | periph_req[j];
    end
  end

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !take |-> ($stable(vec) && $stable(src_id)));
  a_r2_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (take && src_id != 5'd0) |-> $past(boundary));
  a_r3_mask: assert property (@(posedge clk) disable iff (rst)
    (take && src_id >= 5'd5) |-> $past(!cpu_i));
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    xen |=> xen);
  a_r4_gate: assert property (@(posedge clk) disable iff (rst)
    (take && src_id == 5'd1) |-> $past(xen));

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swi_stb = 0, ill_stb = 0, wdog_stb = 0, xirq_lvl = 0, irq_lvl = 0;
  logic [11:0] periph_req = '0;
  logic cpu_i = 1'b1, cpu_x = 1'b1, boundary = 0, pri_we = 0, ack = 0;
  logic [3:0] pri_wdata = '0;
  logic [4:0] ack_id = '0;
  logic take, set_imask;
  logic [15:0] vec;
  logic [4:0] src_id;

  int checks = 0, errors = 0, take_cnt = 0;
  logic [20:0] exp_q[$];
  string tag_q[$];
  logic [20:0] e;
  string t;
  logic prev_rst = 1'b1, prev_take = 1'b0;
  logic [15:0] pvec;
  logic [4:0] pid;

  always #2 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst(rst), .swi_stb(swi_stb), .ill_stb(ill_stb), .wdog_stb(wdog_stb),
    .xirq_lvl(xirq_lvl), .irq_lvl(irq_lvl), .periph_req(periph_req),
    .cpu_i(cpu_i), .cpu_x(cpu_x), .boundary(boundary), .pri_we(pri_we),
    .pri_wdata(pri_wdata), .ack(ack), .ack_id(ack_id),
    .take(take), .set_imask(set_imask), .vec(vec), .src_id(src_id));

  always @(negedge clk) begin
    if (!rst && take) begin
      take_cnt++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected take vec=%h id=%0d, expected none", vec, src_id);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({src_id, vec} !== e) begin
          errors++;
          $display("FAIL %s: vec=%h id=%0d, expected vec=%h id=%0d", t, vec, src_id, e[15:0], e[20:16]);
        end
      end
      checks++;
      if (set_imask !== 1'b1) begin
        errors++;
        $display("FAIL R12: set_imask=%b, expected 1", set_imask);
      end
      if (prev_take) begin
        errors++;
        $display("FAIL R10: take high two cycles, expected a single pulse");
      end
    end
    if (!rst && !prev_rst && !take) begin
      checks++;
      if (vec !== pvec || src_id !== pid) begin
        errors++;
        $display("FAIL R10: vec=%h id=%0d changed without take, expected %h/%0d", vec, src_id, pvec, pid);
      end
    end
    prev_rst = rst; prev_take = take; pvec = vec; pid = src_id;
  end

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_take(logic [15:0] v, logic [4:0] id, string tag);
    exp_q.push_back({id, v});
    tag_q.push_back(tag);
  endtask

  task automatic bpulse();
    boundary = 1'b1; tick(); boundary = 1'b0; tick(2);
  endtask

  task automatic quiet(int n, string tag);
    int c0 = take_cnt;
    tick(n);
    checks++;
    if (take_cnt != c0) begin
      errors++;
      $display("FAIL %s: %0d takes seen, expected 0", tag, take_cnt - c0);
    end
  endtask

  task automatic preq(int k);
    periph_req[k-1] = 1'b1; tick(); periph_req[k-1] = 1'b0;
  endtask

  task automatic do_ack(logic [4:0] id);
    ack = 1'b1; ack_id = id; tick(); ack = 1'b0;
  endtask

  task automatic wprio(logic [3:0] v);
    pri_we = 1'b1; pri_wdata = v; tick(); pri_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R2: watchdog expired, expected the run to finish");
    finish_run();
  end

  initial begin
    tick(3);
    checks++;
    if (take !== 1'b0) begin errors++; $display("FAIL R1: take=%b in reset, expected 0", take); end
    expect_take(16'hFFFE, 5'd0, "R1 reset take");
    rst = 1'b0;
    tick(3);

    // R2: no take without a boundary
    cpu_i = 1'b0; irq_lvl = 1'b1;
    quiet(4, "R2 no boundary");
    expect_take(16'hFFF2, 5'd5, "R2 pin at boundary");
    bpulse();
    irq_lvl = 1'b0;

    // R3: I bit masks the pin but not the software interrupt
    cpu_i = 1'b1; irq_lvl = 1'b1;
    bpulse();
    quiet(3, "R3 masked");
    expect_take(16'hFFF6, 5'd4, "R3 swi ignores I");
    swi_stb = 1'b1; boundary = 1'b1; tick();
    swi_stb = 1'b0; boundary = 1'b0; tick(2);
    irq_lvl = 1'b0;

    // R4: nonmaskable pin enable
    xirq_lvl = 1'b1;
    bpulse();
    quiet(3, "R4 pin disabled");
    cpu_x = 1'b0; tick(); cpu_x = 1'b1; tick();
    expect_take(16'hFFF4, 5'd1, "R4 pin enabled");
    bpulse();
    xirq_lvl = 1'b0;

    // R5: nonmaskable order, strobes latched
    cpu_i = 1'b0;
    wdog_stb = 1'b1; tick(); wdog_stb = 1'b0;
    ill_stb = 1'b1; tick(); ill_stb = 1'b0;
    swi_stb = 1'b1; tick(); swi_stb = 1'b0;
    xirq_lvl = 1'b1; irq_lvl = 1'b1;
    expect_take(16'hFFF4, 5'd1, "R5 pin first (R4 sticky)");
    bpulse();
    xirq_lvl = 1'b0;
    expect_take(16'hFFFA, 5'd2, "R5 watchdog");
    bpulse();
    expect_take(16'hFFF8, 5'd3, "R5 illegal");
    bpulse();
    expect_take(16'hFFF6, 5'd4, "R5 swi");
    bpulse();
    expect_take(16'hFFF2, 5'd5, "R5 maskable last");
    bpulse();
    irq_lvl = 1'b0;

    // R6 / R9: default order and pending latch
    cpu_i = 1'b1;
    preq(6); preq(1); preq(12);
    bpulse();
    quiet(3, "R3 peripherals masked");
    cpu_i = 1'b0;
    expect_take(16'hFFF0, 5'd6, "R6 tick wins");
    bpulse();
    expect_take(16'hFFF0, 5'd6, "R9 kept without ack");
    bpulse();
    do_ack(5'd11);
    expect_take(16'hFFF0, 5'd6, "R9 other ack");
    bpulse();
    do_ack(5'd6);
    expect_take(16'hFFD6, 5'd17, "R9 serial after acks");
    bpulse();
    do_ack(5'd17);
    bpulse();
    quiet(3, "R9 all cleared");

    // R7: promotion
    wprio(4'd10);
    preq(10); preq(2);
    irq_lvl = 1'b1;
    expect_take(16'hFFDE, 5'd15, "R7 promoted overflow");
    bpulse();
    do_ack(5'd15);
    expect_take(16'hFFF2, 5'd5, "R7 rest keep order");
    bpulse();
    irq_lvl = 1'b0;
    expect_take(16'hFFEE, 5'd7, "R7 capture1");
    bpulse();
    do_ack(5'd7);

    // R8: invalid promotion ignored
    wprio(4'd14);
    preq(1); preq(10);
    expect_take(16'hFFDE, 5'd15, "R8 promotion kept");
    bpulse();
    do_ack(5'd15);
    expect_take(16'hFFF0, 5'd6, "R8 then tick");
    bpulse();
    do_ack(5'd6);

    // R11: vector of compare 5
    preq(9);
    expect_take(16'hFFE0, 5'd14, "R11 compare5 vector");
    bpulse();
    do_ack(5'd14);

    // R1: mid-run reset restores defaults
    preq(10);
    rst = 1'b1; tick(2);
    expect_take(16'hFFFE, 5'd0, "R1 mid-run reset");
    rst = 1'b0; tick(3);
    preq(1); preq(10);
    expect_take(16'hFFF0, 5'd6, "R1 default order back");
    bpulse();
    do_ack(5'd6);
    expect_take(16'hFFDE, 5'd15, "R1 overflow after");
    bpulse();
    do_ack(5'd15);
    xirq_lvl = 1'b1;
    bpulse();
    quiet(3, "R1 pin disabled again");
    xirq_lvl = 1'b0;
    tick(2);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d expected takes missing, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule